// File: doc/BRIEF.md
# USB 2.0 PHY Power-Up Sequencer

This block is a hardware state machine that brings a USB 2.0 PHY out of power-down without help from software. A one-cycle start pulse launches a fixed chain of steps. Each step changes isolation, IDDQ, the three analog power-down-bar lines (bandgap, LDO, PLL), core-ready, the two-bit control-mode field, the power-on/power-ok handshake lines or the two reset-bars. The block then holds that step for a set number of microseconds. Each wait is counted in clock cycles from a `CLK_PER_US` parameter and lasts exactly `us * CLK_PER_US` cycles.

Once both reset-bars are released, the block samples the PLL lock input once per microsecond, up to `POLL_TRIES` times. If no lock is seen in that window, it drops the PLL reset-bar for one microsecond, raises it again and opens a second window of the same length. The run ends in either case. The control-mode field takes its non-driving-low code. Then either `done_o` (lock seen) or `fail_o` (both windows missed) goes high and stays high until the next accepted start.

Top module: `u2phy_pwrup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output takes its safe value after that edge: isolation, IDDQ, all power-down-bars, core-ready, power-on, power-ok, both reset-bars, done and fail are 0, and the mode field is `MODE_IDLE` (2'b00).
- R2: A start accepted at edge E0 drives isolation high after E0, with all other outputs at their safe values. IDDQ rises 10 us later (edge E0+10C, where C = `CLK_PER_US`).
- R3: At E0+20C, the mode field takes `MODE_PWRUP` (2'b01 by default). At the same edge, all power-down-bars and core-ready are held low. The block stays in this step for 160 us.
- R4: Core-ready rises at E0+180C. Bandgap power-down-bar rises at E0+230C.
- R5: Power-on and LDO power-down-bar rise together at E0+430C. Power-ok rises at E0+440C.
- R6: PLL power-down-bar rises at E0+450C, isolation falls at E0+460C and IDDQ falls at E0+470C. Both reset-bars rise together at T0 = E0+471C.
- R7: The PLL lock input is sampled only at edges T0+k*C, for k = 1..`POLL_TRIES`. The first sample that finds lock high ends the run with done=1 at that edge. Lock is ignored at all other times.
- R8: If no sample in the first window finds lock, the PLL reset-bar falls at T0+N*C (N = `POLL_TRIES`), while the PHY reset-bar stays high. The PLL reset-bar rises again at T1 = T0+(N+1)*C. The block then samples lock at T1+k*C, for k = 1..N.
- R9: If the second window also misses lock, fail=1 at T1+N*C. Whether the run passes or fails, the mode field becomes `MODE_NDL` (2'b10 by default) at the edge that ends the run.
- R10: Done and fail are never high together. Both hold their values until a new start is accepted. A start that arrives while a run is in progress has no effect.
- R11: A start accepted after a finished run first returns all outputs to their safe values, with isolation high, and then repeats the whole chain with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a power-up run (accepted only when idle) |
| pll_lock_i | input | 1 | PLL lock indication from the PHY |
| iso_o | output | 1 | PHY isolation enable |
| iddq_o | output | 1 | PHY IDDQ (quiescent) enable |
| bg_pdb_o | output | 1 | Bandgap power-down-bar |
| pll_pdb_o | output | 1 | PLL power-down-bar |
| ldo_pdb_o | output | 1 | LDO power-down-bar |
| core_rdy_o | output | 1 | Core-ready |
| mode_o | output | 2 | PHY control-mode field |
| pwr_on_o | output | 1 | Power-switch power-on input |
| pwr_ok_o | output | 1 | Power-switch power-ok input |
| pll_rstb_o | output | 1 | PLL reset-bar |
| phy_rstb_o | output | 1 | PHY reset-bar |
| done_o | output | 1 | Run finished with PLL lock |
| fail_o | output | 1 | Run finished without PLL lock after the retry |

## Verification
The ordering assertions assume that a run starts only after reset has left every output at its safe value. They also assume that reset, when it comes, is held across at least one full clock edge. The bench meets both conditions: it releases reset before the first start and starts each later run only from a finished state. The bench drives `pll_lock_i` as a step that turns on at a chosen cycle. That cycle is swept across the first poll window, the retry gap, the second window and beyond, so each lock-sampling edge is hit. Stray start pulses are inserted only mid-run, where the requirements say they have no effect.

// File: rtl/u2seq_pkg.sv
package u2seq_pkg;

    localparam int STEP_US_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ISO,
        ST_IDDQ,
        ST_PCTL,
        ST_CORE,
        ST_BG,
        ST_LDO,
        ST_PWROK,
        ST_PLLPD,
        ST_UNISO,
        ST_UNIDDQ,
        ST_POLL1,
        ST_PLLRST,
        ST_POLL2
    } seq_state_e;

    typedef struct packed {
        logic       iso;
        logic       iddq;
        logic       bg_pdb;
        logic       pll_pdb;
        logic       ldo_pdb;
        logic       core_rdy;
        logic       pwr_on;
        logic       pwr_ok;
        logic       pll_rstb;
        logic       phy_rstb;
        logic       done;
        logic       fail;
        logic [1:0] mode;
    } phy_ctl_t;

    // Hold time, in microseconds, of the step entered in state s.
    function automatic logic [STEP_US_W-1:0] step_us(seq_state_e s);
        case (s)
            ST_PCTL: step_us = STEP_US_W'(160);
            ST_CORE: step_us = STEP_US_W'(50);
            ST_BG:   step_us = STEP_US_W'(200);
            ST_ISO, ST_IDDQ, ST_LDO, ST_PWROK, ST_PLLPD, ST_UNISO:
                     step_us = STEP_US_W'(10);
            default: step_us = STEP_US_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/u2seq_us_timer.sv
module u2seq_us_timer #(
    parameter int CLK_PER_US = 250,
    parameter int US_W       = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [US_W-1:0] us_i,
    output logic            expire_o
);
    localparam int SUB_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [SUB_W-1:0] SUB_TOP = SUB_W'(CLK_PER_US - 1);

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [US_W-1:0]  us;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.sub = SUB_TOP;
            tmr_d.us  = us_i - 1'b1;
        end else if (tmr_q.sub == '0) begin
            if (tmr_q.us != '0) begin
                tmr_d.sub = SUB_TOP;
                tmr_d.us  = tmr_q.us - 1'b1;
            end
        end else begin
            tmr_d.sub = tmr_q.sub - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expire_o = (tmr_q.sub == '0) && (tmr_q.us == '0);

endmodule

// File: rtl/u2seq_poll_ctr.sv
module u2seq_poll_ctr #(
    parameter int TRIES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CNT_W = $clog2(TRIES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TRIES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == LAST);

endmodule

// File: rtl/u2phy_pwrup_seq.sv
module u2phy_pwrup_seq
    import u2seq_pkg::*;
#(
    parameter int         CLK_PER_US = 250,
    parameter int         POLL_TRIES = 100,
    parameter logic [1:0] MODE_IDLE  = 2'b00,
    parameter logic [1:0] MODE_PWRUP = 2'b01,
    parameter logic [1:0] MODE_NDL   = 2'b10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       pll_lock_i,
    output logic       iso_o,
    output logic       iddq_o,
    output logic       bg_pdb_o,
    output logic       pll_pdb_o,
    output logic       ldo_pdb_o,
    output logic       core_rdy_o,
    output logic [1:0] mode_o,
    output logic       pwr_on_o,
    output logic       pwr_ok_o,
    output logic       pll_rstb_o,
    output logic       phy_rstb_o,
    output logic       done_o,
    output logic       fail_o
);
    localparam int US_W = STEP_US_W;

    typedef struct packed {
        seq_state_e state;
        phy_ctl_t   ctl;
    } seq_t;

    seq_t            seq_d, seq_q;
    logic            tmr_load;
    logic [US_W-1:0] tmr_us;
    logic            tmr_expire;
    logic            poll_clr, poll_inc, poll_last;
    phy_ctl_t        safe_ctl;

    always_comb begin
        safe_ctl      = '0;
        safe_ctl.mode = MODE_IDLE;
    end

    u2seq_us_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .us_i     (tmr_us),
        .expire_o (tmr_expire)
    );

    u2seq_poll_ctr #(.TRIES(POLL_TRIES)) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (poll_clr),
        .inc_i  (poll_inc),
        .last_o (poll_last)
    );

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        poll_clr = 1'b0;
        poll_inc = 1'b0;

        case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.ctl     = safe_ctl;
                    seq_d.ctl.iso = 1'b1;
                    seq_d.state   = ST_ISO;
                    tmr_load      = 1'b1;
                end
            end
            ST_POLL1, ST_POLL2: begin
                if (tmr_expire) begin
                    if (pll_lock_i || poll_last) begin
                        if (!pll_lock_i && seq_q.state == ST_POLL1) begin
                            // First window missed: pulse the PLL reset-bar low.
                            seq_d.ctl.pll_rstb = 1'b0;
                            seq_d.state        = ST_PLLRST;
                            tmr_load           = 1'b1;
                        end else begin
                            seq_d.ctl.mode = MODE_NDL;
                            seq_d.ctl.done = pll_lock_i;
                            seq_d.ctl.fail = !pll_lock_i;
                            seq_d.state    = ST_IDLE;
                        end
                    end else begin
                        poll_inc = 1'b1;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_PLLRST: begin
                if (tmr_expire) begin
                    seq_d.ctl.pll_rstb = 1'b1;
                    seq_d.state        = ST_POLL2;
                    poll_clr           = 1'b1;
                    tmr_load           = 1'b1;
                end
            end
            default: begin
                if (tmr_expire) begin
                    tmr_load = 1'b1;
                    case (seq_q.state)
                        ST_ISO: begin
                            seq_d.ctl.iddq = 1'b1;
                            seq_d.state    = ST_IDDQ;
                        end
                        ST_IDDQ: begin
                            seq_d.ctl.bg_pdb   = 1'b0;
                            seq_d.ctl.pll_pdb  = 1'b0;
                            seq_d.ctl.ldo_pdb  = 1'b0;
                            seq_d.ctl.core_rdy = 1'b0;
                            seq_d.ctl.mode     = MODE_PWRUP;
                            seq_d.state        = ST_PCTL;
                        end
                        ST_PCTL: begin
                            seq_d.ctl.core_rdy = 1'b1;
                            seq_d.state        = ST_CORE;
                        end
                        ST_CORE: begin
                            seq_d.ctl.bg_pdb = 1'b1;
                            seq_d.state      = ST_BG;
                        end
                        ST_BG: begin
                            seq_d.ctl.pwr_on  = 1'b1;
                            seq_d.ctl.ldo_pdb = 1'b1;
                            seq_d.state       = ST_LDO;
                        end
                        ST_LDO: begin
                            seq_d.ctl.pwr_ok = 1'b1;
                            seq_d.state      = ST_PWROK;
                        end
                        ST_PWROK: begin
                            seq_d.ctl.pll_pdb = 1'b1;
                            seq_d.state       = ST_PLLPD;
                        end
                        ST_PLLPD: begin
                            seq_d.ctl.iso = 1'b0;
                            seq_d.state   = ST_UNISO;
                        end
                        ST_UNISO: begin
                            seq_d.ctl.iddq = 1'b0;
                            seq_d.state    = ST_UNIDDQ;
                        end
                        default: begin
                            seq_d.ctl.pll_rstb = 1'b1;
                            seq_d.ctl.phy_rstb = 1'b1;
                            seq_d.state        = ST_POLL1;
                            poll_clr           = 1'b1;
                        end
                    endcase
                end
            end
        endcase

        tmr_us = step_us(seq_d.state);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.ctl   <= safe_ctl;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign iso_o      = seq_q.ctl.iso;
    assign iddq_o     = seq_q.ctl.iddq;
    assign bg_pdb_o   = seq_q.ctl.bg_pdb;
    assign pll_pdb_o  = seq_q.ctl.pll_pdb;
    assign ldo_pdb_o  = seq_q.ctl.ldo_pdb;
    assign core_rdy_o = seq_q.ctl.core_rdy;
    assign mode_o     = seq_q.ctl.mode;
    assign pwr_on_o   = seq_q.ctl.pwr_on;
    assign pwr_ok_o   = seq_q.ctl.pwr_ok;
    assign pll_rstb_o = seq_q.ctl.pll_rstb;
    assign phy_rstb_o = seq_q.ctl.phy_rstb;
    assign done_o     = seq_q.ctl.done;
    assign fail_o     = seq_q.ctl.fail;

endmodule

// File: rtl/u2seq_checker.sv
module u2seq_checker #(
    parameter logic [1:0] MODE_IDLE  = 2'b00,
    parameter logic [1:0] MODE_PWRUP = 2'b01,
    parameter logic [1:0] MODE_NDL   = 2'b10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       iso_o,
    input logic       iddq_o,
    input logic       bg_pdb_o,
    input logic       pll_pdb_o,
    input logic       ldo_pdb_o,
    input logic       core_rdy_o,
    input logic [1:0] mode_o,
    input logic       pwr_on_o,
    input logic       pwr_ok_o,
    input logic       pll_rstb_o,
    input logic       phy_rstb_o,
    input logic       done_o,
    input logic       fail_o
);
    assert_safe_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!iso_o && !iddq_o && !bg_pdb_o && !pll_pdb_o && !ldo_pdb_o &&
                    !core_rdy_o && !pwr_on_o && !pwr_ok_o && !pll_rstb_o &&
                    !phy_rstb_o && !done_o && !fail_o && mode_o == MODE_IDLE));

    assert_core_rdy_in_pwrup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rdy_o) |-> (mode_o == MODE_PWRUP && !bg_pdb_o && iso_o && iddq_o));

    assert_ldo_with_pwr_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ldo_pdb_o) |-> (pwr_on_o && bg_pdb_o && !pwr_ok_o));

    assert_resets_after_power_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_rstb_o) |-> (pll_rstb_o && !iso_o && !iddq_o && pll_pdb_o && pwr_ok_o));

    assert_mode_ndl_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_o) || $rose(fail_o)) |-> (mode_o == MODE_NDL && phy_rstb_o));

    assert_done_fail_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

    assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_o || fail_o) && !start_i) |=> ($stable(done_o) && $stable(fail_o)));

endmodule

bind u2phy_pwrup_seq u2seq_checker #(
    .MODE_IDLE  (MODE_IDLE),
    .MODE_PWRUP (MODE_PWRUP),
    .MODE_NDL   (MODE_NDL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .iso_o      (iso_o),
    .iddq_o     (iddq_o),
    .bg_pdb_o   (bg_pdb_o),
    .pll_pdb_o  (pll_pdb_o),
    .ldo_pdb_o  (ldo_pdb_o),
    .core_rdy_o (core_rdy_o),
    .mode_o     (mode_o),
    .pwr_on_o   (pwr_on_o),
    .pwr_ok_o   (pwr_ok_o),
    .pll_rstb_o (pll_rstb_o),
    .phy_rstb_o (phy_rstb_o),
    .done_o     (done_o),
    .fail_o     (fail_o)
);

// File: tb/u2phy_pwrup_seq_tb.sv
module u2phy_pwrup_seq_tb;
    localparam int C  = 2;
    localparam int N  = 4;
    localparam int T0 = 471 * C;
    localparam int T1 = T0 + (N + 1) * C;
    localparam logic [1:0] M_IDLE = 2'b00;
    localparam logic [1:0] M_PWR  = 2'b01;
    localparam logic [1:0] M_NDL  = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic pll_lock_i = 1'b0;
    logic iso_o, iddq_o, bg_pdb_o, pll_pdb_o, ldo_pdb_o, core_rdy_o;
    logic [1:0] mode_o;
    logic pwr_on_o, pwr_ok_o, pll_rstb_o, phy_rstb_o, done_o, fail_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    u2phy_pwrup_seq #(.CLK_PER_US(C), .POLL_TRIES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pll_lock_i(pll_lock_i),
        .iso_o(iso_o), .iddq_o(iddq_o), .bg_pdb_o(bg_pdb_o), .pll_pdb_o(pll_pdb_o),
        .ldo_pdb_o(ldo_pdb_o), .core_rdy_o(core_rdy_o), .mode_o(mode_o),
        .pwr_on_o(pwr_on_o), .pwr_ok_o(pwr_ok_o), .pll_rstb_o(pll_rstb_o),
        .phy_rstb_o(phy_rstb_o), .done_o(done_o), .fail_o(fail_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL R10 watchdog expired actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Order: iso iddq bg pll ldo core on ok pllrstb phyrstb done fail mode[1:0]
    function automatic logic [13:0] act_vec();
        return {iso_o, iddq_o, bg_pdb_o, pll_pdb_o, ldo_pdb_o, core_rdy_o, pwr_on_o,
                pwr_ok_o, pll_rstb_o, phy_rstb_o, done_o, fail_o, mode_o};
    endfunction

    localparam logic [13:0] SAFE = {12'b0, M_IDLE};

    function automatic logic [13:0] exp_vec(int t, int fin, bit ok, bit retry);
        logic [1:0] m;
        logic prst;
        m = (t < 20 * C) ? M_IDLE : ((t < fin) ? M_PWR : M_NDL);
        prst = (t >= T0) && !(retry && t >= T0 + N * C && t < T1);
        return {t < 460 * C, (t >= 10 * C) && (t < 470 * C), t >= 230 * C, t >= 450 * C,
                t >= 430 * C, t >= 180 * C, t >= 430 * C, t >= 440 * C, prst, t >= T0,
                (t >= fin) && ok, (t >= fin) && !ok, m};
    endfunction

    function automatic string req_of(int t, int fin, bit retry, bit later);
        if (t >= fin)     return "R10";
        if (t == 0)       return later ? "R11" : "R2";
        if (t < 20 * C)   return "R2";
        if (t < 180 * C)  return "R3";
        if (t < 430 * C)  return "R4";
        if (t < 450 * C)  return "R5";
        if (t < T0 + C)   return "R6";
        if (!retry)       return "R7";
        if (t < T1)       return "R8";
        return "R9";
    endfunction

    task automatic check(string req, logic [13:0] act, logic [13:0] exp, int t);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s t=%0d actual=%b expected=%b", req, t, act, exp);
        end
    endtask

    task automatic run(int lock_at, bit later);
        int fin;
        bit ok;
        bit retry;
        fin = T1 + N * C;
        ok = 1'b0;
        retry = 1'b1;
        for (int k = N; k >= 1; k--)
            if (T1 + k * C - 1 >= lock_at) begin fin = T1 + k * C; ok = 1'b1; end
        for (int k = N; k >= 1; k--)
            if (T0 + k * C - 1 >= lock_at) begin fin = T0 + k * C; ok = 1'b1; retry = 1'b0; end
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int t = 0; t <= fin + 6; t++) begin
            check(req_of(t, fin, retry, later), act_vec(), exp_vec(t, fin, ok, retry), t);
            pll_lock_i = (t >= lock_at);
            start_i = (t == 100) || (t == fin + 2 && 1'b0);
            @(negedge clk);
        end
        start_i = 1'b0;
        pll_lock_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", act_vec(), SAFE, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", act_vec(), SAFE, 0);
        // R7: lock early, at first sample, at second sample, at last sample of window 1
        run(0, 1'b0);
        run(T0 + 2 * C - 1, 1'b1);
        run(T0 + N * C - 1, 1'b1);
        // R8: lock during the reset gap, and at the last sample of window 2
        run(T0 + N * C, 1'b1);
        run(T1 + N * C - 1, 1'b1);
        // R9: lock never arrives
        run(1000000, 1'b1);
        // R1: reset in the middle of a run
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", act_vec(), SAFE, 0);
        repeat (5) @(negedge clk);
        check("R1", act_vec(), SAFE, 5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule